// File: doc/BRIEF.md
# Sigma-Delta Bitstream Sample Counter

This block converts the one-bit output of a sigma-delta modulator into numeric samples by counting the clock cycles on which the selected bit is high. It has four bitstream inputs: a ground calibration stream, a supply calibration stream, pin A and pin B. A two-bit source field in the mode word picks one of them. Software writes three things: a mode word, a period and an initial accumulator value.

With a zero period the block runs as a free-running rolling counter. Software reads the count twice and takes the difference. With a non-zero period the block closes a window every period clocks and latches the ones count of that window itself. It then raises a ready flag, which a read clears. Longer windows give a larger full-scale count and finer resolution. For example, a 160-clock window at 160 MHz yields one million samples per second. Switching only the source in the middle of a window does not restart anything.

Top module: `sd_sample_counter`

## Requirements
- R1: A mode write that sets the enable bit (mode bit 0) while the block is disabled loads the initial-value register into the accumulator on that clock edge.
- R2: While the block is enabled, the accumulator advances by one on each clock edge at which the selected bit is high. While it is disabled, the accumulator holds its value.
- R3: Mode bits 2:1 select the source: 00 ground calibration, 01 supply calibration, 11 pin A, 10 pin B.
- R4: With a zero period, result_o shows the live accumulator, which wraps modulo 2^32, and ready_o never rises.
- R5: With a non-zero period P, the clock edge that ends each window of P edges latches that window's ones count into result_o and sets ready_o.
- R6: A read strobe clears ready_o.
- R7: If a window closes while ready_o is still set and no read strobe is present, the new sample overwrites the old one and overrun_o becomes set and stays set.
- R8: A period write, or a mode write that changes the enable bit, restarts the window and clears ready_o and overrun_o.
- R9: A mode write that changes only the source field neither restarts the window nor disturbs the count. The edge of that write still counts the previously selected source.
- R10: After reset, result_o, ready_o and overrun_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gnd_bit_i | input | 1 | Ground calibration bitstream |
| sup_bit_i | input | 1 | Supply calibration bitstream |
| pin_a_bit_i | input | 1 | Pin A bitstream |
| pin_b_bit_i | input | 1 | Pin B bitstream |
| mode_we_i | input | 1 | Mode write strobe |
| mode_i | input | 3 | Mode: bit 0 enable, bits 2:1 source |
| period_we_i | input | 1 | Period write strobe |
| period_i | input | PER_W | Window length in clocks, 0 for rolling |
| init_we_i | input | 1 | Initial-value write strobe |
| init_i | input | ACC_W | Initial accumulator value |
| rd_i | input | 1 | Result read strobe |
| result_o | output | ACC_W | Live count or latched sample |
| ready_o | output | 1 | Sample ready flag |
| overrun_o | output | 1 | Sticky overrun flag |

## Verification
The bench builds the block with its default 32-bit accumulator and 32-bit period. It uses windows of 4, 8 and 10 clocks, so several windows close, overlap without a read and restart within a few dozen cycles. An initial value just below 2^32 brings rolling wrap-around within twenty clocks. A window that spans a source-only mode write shows that the count is carried across the switch, and it also exercises the pin B encoding.

// File: rtl/sd_pkg.sv
package sd_pkg;
  typedef enum logic [1:0] {
    SRC_GND  = 2'b00,
    SRC_SUP  = 2'b01,
    SRC_PINB = 2'b10,
    SRC_PINA = 2'b11
  } src_e;
  localparam int unsigned NUM_SRC = 4;
endpackage

// File: rtl/sd_src_mux.sv
module sd_src_mux
  import sd_pkg::*;
(
  input  src_e                 sel_i,
  input  logic [NUM_SRC-1:0]   bits_i,
  output logic                 bit_o
);
  // bits_i is indexed by the selector code
  always_comb begin
    bit_o = 1'b0;
    for (int k = 0; k < NUM_SRC; k++)
      if (sel_i == src_e'(k)) bit_o = bits_i[k];
  end
endmodule

// File: rtl/sd_window_timer.sv
module sd_window_timer #(
  parameter int unsigned PER_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [PER_W-1:0] period_i,
  output logic             close_o
);
  logic [PER_W-1:0] win_q;
  logic             windowed, last;

  assign windowed = (period_i != '0);
  assign last     = (win_q == period_i - 1'b1);
  assign close_o  = run_i && !restart_i && windowed && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   win_q <= '0;
    else if (restart_i)            win_q <= '0;
    else if (run_i && windowed)    win_q <= last ? '0 : win_q + 1'b1;
  end

  assert_win_in_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    windowed |-> (win_q < period_i));
endmodule

// File: rtl/sd_accum.sv
module sd_accum #(
  parameter int unsigned ACC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             load_i,
  input  logic [ACC_W-1:0] load_val_i,
  input  logic             bit_i,
  input  logic             snap_i,
  output logic [ACC_W-1:0] acc_o,
  output logic [ACC_W-1:0] diff_o
);
  logic [ACC_W-1:0] acc_q, snap_q, acc_nxt;

  assign acc_nxt = acc_q + ACC_W'(bit_i);
  assign acc_o   = acc_q;
  assign diff_o  = acc_nxt - snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      snap_q <= '0;
    end else if (load_i) begin
      acc_q  <= load_val_i;
      snap_q <= load_val_i;
    end else if (en_i) begin
      acc_q <= acc_nxt;
      if (snap_i) snap_q <= acc_nxt;
    end
  end

  assert_step_le_one_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i) |=> ((acc_q - $past(acc_q)) <= ACC_W'(1)));
  assert_hold_disabled_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load_i) |=> $stable(acc_q));
endmodule

// File: rtl/sd_sample_counter.sv
module sd_sample_counter
  import sd_pkg::*;
#(
  parameter int unsigned ACC_W = 32,
  parameter int unsigned PER_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gnd_bit_i,
  input  logic             sup_bit_i,
  input  logic             pin_a_bit_i,
  input  logic             pin_b_bit_i,
  input  logic             mode_we_i,
  input  logic [2:0]       mode_i,
  input  logic             period_we_i,
  input  logic [PER_W-1:0] period_i,
  input  logic             init_we_i,
  input  logic [ACC_W-1:0] init_i,
  input  logic             rd_i,
  output logic [ACC_W-1:0] result_o,
  output logic             ready_o,
  output logic             overrun_o
);
  logic             en_q, ready_q, ovr_q;
  src_e             sel_q;
  logic [PER_W-1:0] period_q;
  logic [ACC_W-1:0] init_q, result_q, acc, diff;
  logic             en_change, load, restart, close, sel_bit;
  logic [NUM_SRC-1:0] src_bits;

  assign en_change = mode_we_i && (mode_i[0] != en_q);
  assign load      = en_change && mode_i[0];
  assign restart   = period_we_i || en_change;
  assign src_bits  = {pin_a_bit_i, pin_b_bit_i, sup_bit_i, gnd_bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      sel_q    <= SRC_GND;
      period_q <= '0;
      init_q   <= '0;
    end else begin
      if (mode_we_i)   begin en_q <= mode_i[0]; sel_q <= src_e'(mode_i[2:1]); end
      if (period_we_i) period_q <= period_i;
      if (init_we_i)   init_q   <= init_i;
    end
  end

  sd_src_mux u_mux (.sel_i(sel_q), .bits_i(src_bits), .bit_o(sel_bit));

  sd_window_timer #(.PER_W(PER_W)) u_timer (
    .clk_i, .rst_ni, .run_i(en_q), .restart_i(restart),
    .period_i(period_q), .close_o(close)
  );

  sd_accum #(.ACC_W(ACC_W)) u_acc (
    .clk_i, .rst_ni, .en_i(en_q), .load_i(load), .load_val_i(init_q),
    .bit_i(sel_bit), .snap_i(close || restart), .acc_o(acc), .diff_o(diff)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q  <= 1'b0;
      ovr_q    <= 1'b0;
      result_q <= '0;
    end else if (restart) begin
      ready_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (close) begin
        result_q <= diff;
        ready_q  <= 1'b1;
        if (ready_q && !rd_i) ovr_q <= 1'b1;
      end else if (rd_i) begin
        ready_q <= 1'b0;
      end
    end
  end

  assign result_o  = (period_q == '0) ? acc : result_q;
  assign ready_o   = ready_q;
  assign overrun_o = ovr_q;

  assert_no_ready_rolling_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_q == '0) |-> !ready_o);
  assert_restart_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_we_i |=> (!ready_o && !overrun_o));
  assert_overrun_needs_ready_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> $past(ready_o));
  assert_read_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && ready_o && !close) |=> !ready_o);
endmodule

// File: tb/sd_sample_counter_test.sv
module sd_sample_counter_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        gnd_b = 1'b0, sup_b = 1'b1, pa_b = 1'b0, pb_b = 1'b0;
  logic        mode_we = 1'b0, period_we = 1'b0, init_we = 1'b0, rd = 1'b0;
  logic [2:0]  mode = '0;
  logic [31:0] period = '0, init = '0;
  logic [31:0] result;
  logic        ready, overrun;
  int          checks = 0, errors = 0;

  always #5 clk = ~clk;

  sd_sample_counter uut (
    .clk_i(clk), .rst_ni(rst_n), .gnd_bit_i(gnd_b), .sup_bit_i(sup_b),
    .pin_a_bit_i(pa_b), .pin_b_bit_i(pb_b), .mode_we_i(mode_we), .mode_i(mode),
    .period_we_i(period_we), .period_i(period), .init_we_i(init_we), .init_i(init),
    .rd_i(rd), .result_o(result), .ready_o(ready), .overrun_o(overrun)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr_mode(logic [2:0] m);
    mode = m; mode_we = 1'b1; tick(); mode_we = 1'b0;
  endtask
  task automatic wr_period(logic [31:0] p);
    period = p; period_we = 1'b1; tick(); period_we = 1'b0;
  endtask
  task automatic wr_init(logic [31:0] v);
    init = v; init_we = 1'b1; tick(); init_we = 1'b0;
  endtask
  task automatic do_read();
    rd = 1'b1; tick(); rd = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 result", result, 0);
    chk("R10 ready", {31'b0, ready}, 0);
    chk("R10 overrun", {31'b0, overrun}, 0);
  endtask

  task automatic t_rolling();
    wr_init(32'd100);
    wr_period(0);
    wr_mode(3'b011);                 // enable, supply (01)
    chk("R1 init load", result, 100);
    repeat (20) tick();
    chk("R2 R3 supply count", result, 120);
    chk("R4 no ready rolling", {31'b0, ready}, 0);
    wr_mode(3'b000);
    wr_init(32'hFFFF_FFF0);
    wr_mode(3'b011);
    repeat (20) tick();
    chk("R4 wrap", result, 32'd4);
  endtask

  task automatic t_disabled_hold();
    logic [31:0] held;
    wr_mode(3'b010);                 // disable
    held = result;
    repeat (10) tick();
    chk("R2 hold when disabled", result, held);
    wr_init(32'd50);
    wr_mode(3'b001);                 // enable, ground (00)
    repeat (10) tick();
    chk("R3 ground source", result, 50);
    wr_mode(3'b000);
  endtask

  task automatic t_window();
    int ones = 0;
    wr_init(0);
    wr_mode(3'b111);                 // enable, pin A (11)
    wr_period(8);
    for (int i = 0; i < 8; i++) begin
      pa_b = i[0]; pb_b = ~i[0];
      if (i[0]) ones++;
      tick();
      if (i == 6) chk("R5 not ready early", {31'b0, ready}, 0);
    end
    chk("R5 ready at window end", {31'b0, ready}, 1);
    chk("R5 R3 pin A count", result, ones);
    do_read();
    chk("R6 read clears ready", {31'b0, ready}, 0);
  endtask

  task automatic t_overrun();
    wr_period(4);
    pa_b = 1'b1;
    repeat (4) tick();
    chk("R5 full window", result, 4);
    pa_b = 1'b0;
    repeat (4) tick();
    chk("R7 overwrite", result, 0);
    chk("R7 overrun set", {31'b0, overrun}, 1);
    chk("R7 ready still set", {31'b0, ready}, 1);
    wr_period(4);
    chk("R8 restart clears ready", {31'b0, ready}, 0);
    chk("R8 restart clears overrun", {31'b0, overrun}, 0);
  endtask

  task automatic t_src_switch();
    pa_b = 1'b1; pb_b = 1'b0;
    wr_period(10);
    repeat (5) tick();
    wr_mode(3'b101);                 // enable kept, pin B (10); edge counts pin A
    repeat (3) tick();
    chk("R9 no early close", {31'b0, ready}, 0);
    tick();
    chk("R9 window not restarted", {31'b0, ready}, 1);
    chk("R9 R3 count across switch", result, 6);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_rolling();
    t_disabled_hold();
    t_window();
    t_overrun();
    t_src_switch();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule